// File: doc/BRIEF.md
# Board Interrupt Level Encoder

This block collects thirteen level-sensitive interrupt request lines on a board and presents them to a processor as one 4-bit encoded priority level. Every request line has a fixed bit in a 16-bit monitor word and a fixed priority level. The two orders are unrelated. The monitor word is gated by a software-written enable mask. Among the requests that stay pending, the lowest-numbered level wins. The winning level is driven inverted, so an all-zero code means that nothing is requested.

A small 16-bit register window on a synchronous read/write bus holds the enable mask, a power-off register, a general output register and a constant version word. The power-off and output registers drive nothing inside the block. Their contents go straight out on ports for board logic to use.

Top module: `irl_board_encoder`

## Requirements
- R1: After a synchronous active-low reset, the mask, power-off and output registers are 0, the level code is 0 and the read data is 0, even while request lines are high.
- R2: Request input index maps to (monitor bit, level) as follows: 0:(9,1), 1:(8,2), 2:(14,9), 3:(13,10), 4:(12,3), 5:(11,0), 6:(10,4), 7:(6,5), 8:(5,6), 9:(4,7), 10:(7,8), 11:(0,11), 12:(15,12). Monitor bits 1, 2 and 3 belong to no request.
- R3: A request is pending only while its input is high and its monitor bit is set in the mask. When the input falls, the request stops being pending.
- R4: Among the pending requests, the smallest level wins. With nothing pending, the internal level is 15.
- R5: The level code output equals the winning level XOR 15. Level 0 gives 15, and the idle state gives 0.
- R6: The level code is registered. It reflects the request inputs and the mask value that are present at a clock edge, starting right after that edge. A mask write therefore takes effect on the code at the same edge that stores it.
- R7: Byte offset 0x00 is the mask register, read and write, all 16 bits stored.
- R8: Offset 0x30 (power-off) and offset 0x36 (output port) are read/write registers. Their values appear on the pwr_reg and gpo_reg ports.
- R9: Offset 0x32 always reads 0x0010. Writes to it change nothing.
- R10: Every other offset in the 64-byte window reads 0. Writes to those offsets change no register and no output.
- R11: Read data is valid on the cycle after a read strobe and shows the register value before any write in the same cycle. In cycles that follow no read strobe, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 6 | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the strobe |
| src_req | input | 13 | Level-sensitive request lines |
| irl_code | output | 4 | Inverted winning priority level |
| pwr_reg | output | 16 | Power-off register contents |
| gpo_reg | output | 16 | Output port register contents |

## Verification
Every one of the 8192 request combinations is applied under five mask patterns: all set, all clear, alternating in both phases, and nibble-striped. The full sweep shows whether the bit mapping and the level mapping were crossed, and whether the mask is applied at the right bit. The alternating masks also catch a priority search that stops at the first index instead of at the lowest level. Single-request and single-mask-bit walks isolate each table entry on its own. A sweep over all 64 offsets, with a write and a read-back at each, separates the decoded registers from the unmapped space. Dedicated sequences cover the same-edge effect of a mask write and the falling edge of a request.

// File: rtl/irl_pkg.sv
// Shared constants and request-to-bit / request-to-level mapping for the
// board interrupt level encoder. Assumes at most 16 requests and 16-bit data.
package irl_pkg;
    localparam int NUM_SRC = 13;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 6;
    localparam int LVL_W   = 4;

    localparam logic [ADDR_W-1:0] OFS_MASK = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_PWR  = 6'h30;
    localparam logic [ADDR_W-1:0] OFS_VER  = 6'h32;
    localparam logic [ADDR_W-1:0] OFS_GPO  = 6'h36;
    localparam logic [DATA_W-1:0] VER_WORD = 16'h0010;

    // Monitor/mask bit owned by request index i.
    function automatic int src_bit(input int i);
        case (i)
            0: return 9;    1: return 8;    2: return 14;   3: return 13;
            4: return 12;   5: return 11;   6: return 10;   7: return 6;
            8: return 5;    9: return 4;    10: return 7;   11: return 0;
            12: return 15;
            default: return 1;
        endcase
    endfunction

    // Priority level of request index i (smaller wins).
    function automatic int src_lvl(input int i);
        case (i)
            0: return 1;    1: return 2;    2: return 9;    3: return 10;
            4: return 3;    5: return 0;    6: return 4;    7: return 5;
            8: return 6;    9: return 7;    10: return 8;   11: return 11;
            12: return 12;
            default: return 15;
        endcase
    endfunction
endpackage

// File: rtl/irl_regfile.sv
// Register window: mask, power-off, output port, constant version word.
// Assumes a single-cycle bus; read data is registered and zero when idle.
// Also exports the next mask value so the encoder sees a write at once.
module irl_regfile #(
    parameter int DATA_W = irl_pkg::DATA_W,
    parameter int ADDR_W = irl_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] mask_nxt,
    output logic [DATA_W-1:0] pwr_q,
    output logic [DATA_W-1:0] gpo_q
);
    import irl_pkg::*;

    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] rd_mux;

    // Next mask: the write data when the mask offset is written.
    always_comb begin
        mask_nxt = mask_q;
        if (wr && addr == OFS_MASK) mask_nxt = wdata;
    end

    // Read decode; unmapped offsets yield zero.
    always_comb begin
        case (addr)
            OFS_MASK: rd_mux = mask_q;
            OFS_PWR:  rd_mux = pwr_q;
            OFS_VER:  rd_mux = VER_WORD;
            OFS_GPO:  rd_mux = gpo_q;
            default:  rd_mux = '0;
        endcase
    end

    // Register updates and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pwr_q  <= '0;
            gpo_q  <= '0;
            rdata  <= '0;
        end else begin
            mask_q <= mask_nxt;
            if (wr && addr == OFS_PWR) pwr_q <= wdata;
            if (wr && addr == OFS_GPO) gpo_q <= wdata;
            rdata <= rd ? rd_mux : '0;
        end
    end

    AST_VER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == OFS_VER) |=> rdata == VER_WORD); // R9
    AST_PWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == OFS_PWR) |=> $stable(pwr_q)); // R10
    AST_GPO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == OFS_GPO) |=> $stable(gpo_q)); // R10
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> rdata == '0); // R11
endmodule

// File: rtl/irl_prio.sv
// Builds the monitor word from the request lines, gates it with the mask,
// finds the smallest pending level and registers its inverse as the code.
// Assumes mask_in already carries a write made in the current cycle.
module irl_prio #(
    parameter int NUM_SRC = irl_pkg::NUM_SRC,
    parameter int DATA_W  = irl_pkg::DATA_W,
    parameter int LVL_W   = irl_pkg::LVL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [DATA_W-1:0]  mask_in,
    output logic [LVL_W-1:0]   irl_code
);
    import irl_pkg::*;

    localparam int TOP_SRC = 5;

    logic [DATA_W-1:0] mon_w;
    logic [DATA_W-1:0] pend;
    logic [LVL_W-1:0]  best;

    // Scatter request lines onto their monitor bits.
    always_comb begin
        mon_w = '0;
        for (int i = 0; i < NUM_SRC; i++) mon_w[src_bit(i)] = src_req[i];
    end

    assign pend = mon_w & mask_in;

    // Smallest level among pending requests; all ones when none.
    always_comb begin
        best = '1;
        for (int i = 0; i < NUM_SRC; i++)
            if (pend[src_bit(i)] && (LVL_W'(src_lvl(i)) < best))
                best = LVL_W'(src_lvl(i));
    end

    // Register the inverted winning level.
    always_ff @(posedge clk) begin
        if (!rst_n) irl_code <= '0;
        else        irl_code <= best ^ {LVL_W{1'b1}};
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> irl_code == '0); // R4
    AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req[TOP_SRC] && mask_in[src_bit(TOP_SRC)]) |=> irl_code == '1); // R5
    AST_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_in == '0) |=> irl_code == '0); // R3
endmodule

// File: rtl/irl_board_encoder.sv
// Top of the board interrupt level encoder: register window plus priority
// encoder. Assumes one clock domain and a synchronous active-low reset.
module irl_board_encoder #(
    parameter int NUM_SRC = irl_pkg::NUM_SRC,
    parameter int DATA_W  = irl_pkg::DATA_W,
    parameter int ADDR_W  = irl_pkg::ADDR_W,
    parameter int LVL_W   = irl_pkg::LVL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    output logic [LVL_W-1:0]   irl_code,
    output logic [DATA_W-1:0]  pwr_reg,
    output logic [DATA_W-1:0]  gpo_reg
);
    logic [DATA_W-1:0] mask_nxt;

    irl_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .rdata(bus_rdata), .mask_nxt(mask_nxt),
        .pwr_q(pwr_reg), .gpo_q(gpo_reg)
    );

    irl_prio #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .mask_in(mask_nxt),
        .irl_code(irl_code)
    );
endmodule

// File: tb/sim_irl_board_encoder.sv
module sim_irl_board_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [12:0] src_req = '0;
    logic [3:0]  irl_code;
    logic [15:0] pwr_reg;
    logic [15:0] gpo_reg;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Bench copy of the mapping from the requirements (R2).
    int tb_bit [13] = '{9, 8, 14, 13, 12, 11, 10, 6, 5, 4, 7, 0, 15};
    int tb_lvl [13] = '{1, 2, 9, 10, 3, 0, 4, 5, 6, 7, 8, 11, 12};

    always #2 clk = ~clk;

    irl_board_encoder u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_req(src_req), .irl_code(irl_code), .pwr_reg(pwr_reg),
        .gpo_reg(gpo_reg)
    );

    function automatic int exp_code(input logic [12:0] s, input logic [15:0] m);
        int lv = 15;
        for (int i = 0; i < 13; i++)
            if (s[i] && m[tb_bit[i]] && tb_lvl[i] < lv) lv = tb_lvl[i];
        return lv ^ 15;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 190000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        logic [15:0] masks [5] = '{16'hFFFF, 16'h0000, 16'hAAAA, 16'h5555, 16'hF0F0};

        // R1: reset with all requests high
        src_req = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irl", irl_code, 0);
        chk("R1 pwr", pwr_reg, 0);
        chk("R1 gpo", gpo_reg, 0);
        chk("R1 rdata", bus_rdata, 0);
        rd_reg(6'h00, d);
        chk("R1 mask", d, 0);

        // R2 R4 R5: full sweep under several masks
        foreach (masks[k]) begin
            wr_reg(6'h00, masks[k]);
            for (int s = 0; s < 8192; s++) begin
                src_req = 13'(s);
                @(negedge clk);
                chk("R4 sweep", irl_code, exp_code(13'(s), masks[k]));
            end
        end

        // R2 R5: single request walk, all mask bits set
        wr_reg(6'h00, 16'hFFFF);
        for (int i = 0; i < 13; i++) begin
            src_req = 13'(1) << i;
            @(negedge clk);
            chk("R2 single", irl_code, tb_lvl[i] ^ 15);
        end

        // R2 R3: single mask bit walk, all requests high
        src_req = '1;
        for (int b = 0; b < 16; b++) begin
            wr_reg(6'h00, 16'(1) << b);
            chk("R3 maskbit", irl_code, exp_code('1, 16'(1) << b));
        end

        // R3: falling request clears pending
        wr_reg(6'h00, 16'hFFFF);
        src_req = 13'(1);
        @(negedge clk);
        chk("R3 high", irl_code, 14);
        src_req = '0;
        @(negedge clk);
        chk("R3 low", irl_code, 0);

        // R6: mask write acts at the storing edge
        src_req = 13'(1) << 12;
        wr_reg(6'h00, 16'h0000);
        chk("R6 off", irl_code, 0);
        @(negedge clk);
        bus_addr = 6'h00; bus_wdata = 16'h8000; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R6 same edge", irl_code, 3);

        // R7 R8 R9 R11: register access
        wr_reg(6'h00, 16'hC3A5);
        rd_reg(6'h00, d);
        chk("R7 mask rb", d, 16'hC3A5);
        wr_reg(6'h30, 16'h1234);
        wr_reg(6'h36, 16'hABCD);
        rd_reg(6'h30, d);
        chk("R8 pwr rb", d, 16'h1234);
        chk("R8 pwr port", pwr_reg, 16'h1234);
        rd_reg(6'h36, d);
        chk("R8 gpo rb", d, 16'hABCD);
        chk("R8 gpo port", gpo_reg, 16'hABCD);
        wr_reg(6'h32, 16'hFFFF);
        rd_reg(6'h32, d);
        chk("R9 version", d, 16'h0010);
        @(negedge clk);
        chk("R11 idle", bus_rdata, 0);
        // R11: read and write together returns the older value
        @(negedge clk);
        bus_addr = 6'h30; bus_wdata = 16'h7777; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R11 old value", bus_rdata, 16'h1234);
        wr_reg(6'h30, 16'h1234);

        // R10: unmapped offsets
        wr_reg(6'h00, 16'hFFFF);
        src_req = 13'(1) << 11;
        for (int a = 0; a < 64; a++) begin
            if (a == 6'h00 || a == 6'h30 || a == 6'h32 || a == 6'h36) continue;
            wr_reg(6'(a), 16'h5A5A);
            rd_reg(6'(a), d);
            chk("R10 read zero", d, 0);
        end
        rd_reg(6'h00, d);
        chk("R10 mask kept", d, 16'hFFFF);
        chk("R10 pwr kept", pwr_reg, 16'h1234);
        chk("R10 gpo kept", gpo_reg, 16'hABCD);
        chk("R10 irl kept", irl_code, 11 ^ 15);

        finish_run();
    end
endmodule